// File: doc/BRIEF.md
# Multiframe Q-Bit Transmit Scheduler

This block places host-supplied Q bits into the FA/Q bit position of each frame that a terminal sends toward the network on an S/T interface. Frames are grouped into a 20-frame multiframe. A host writes a 5-bit buffer through a simple write port. Bit 4 of that buffer is a fallback value. Bits 3 down to 0 form the four-bit Q pattern. A buffer-empty flag tells the host when it may load new data. Reading the status clears that flag.

The framer in front of the block gives it a one-cycle frame strobe and the position of the current frame, from 1 to 20. It also gives two levels: one says whether multiframing is enabled, the other whether multiframe sync is held. Line coding, the line-interface state machine and multiframe acquisition are all handled outside this block. For every frame strobe the block returns the FA/Q bit for that frame.

Top module: `qsched_tx`

## Requirements
- R1: After reset `buf_empty` is 1. It is also set to 1 by a handover, which is a frame strobe at position 1 while `mf_en` and `mf_sync` are both 1.
- R2: A `stat_rd` pulse clears `buf_empty` to 0 on the next clock edge. If a handover falls in the same cycle as the read, the handover wins and the flag stays at 1.
- R3: While `mf_en`=1 and `mf_sync`=0, each frame strobe outputs buffer bit 4. The value used is the one held at that clock edge; a write in the same cycle takes effect only afterwards.
- R4: Reset sets every buffer bit to 0. A strobe in hunt mode straight after reset therefore outputs 0.
- R5: While `mf_en`=1 and `mf_sync`=1, the pattern is sent in a fixed order. Position 1 carries pattern bit 3 (Q1), position 6 bit 2 (Q2), position 11 bit 1 (Q3) and position 16 bit 0 (Q4). At position 1 the pattern is taken from the buffer at the handover edge.
- R6: While in sync, every position other than 1, 6, 11 and 16 outputs 0.
- R7: If the host does not reload the buffer, the same Q1..Q4 pattern is sent again in the next multiframe.
- R8: A buffer write made after the handover does not change positions 6, 11 or 16 of the current multiframe.
- R9: While `mf_sync`=0, no handover takes place. After a status read, `buf_empty` stays 0. When sync returns, the next position-1 strobe latches the current buffer.
- R10: While `mf_en`=0, every frame strobe outputs 1.
- R11: `q_bit` is registered. It takes its new value on the clock edge of the strobe, holds it between strobes, and resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Buffer write strobe |
| host_wdata | input | 5 | Bit 4 is the fallback; bits 3..0 are Q1..Q4 |
| stat_rd | input | 1 | Status read strobe; clears the empty flag |
| frame_stb | input | 1 | One-cycle pulse per frame |
| frame_idx | input | 5 | Frame position in the multiframe, 1..20 |
| mf_en | input | 1 | Multiframing enabled |
| mf_sync | input | 1 | Multiframe sync established |
| q_bit | output | 1 | FA/Q bit for the current frame |
| buf_empty | output | 1 | Buffer may be reloaded |

## Verification
The assertions check these rules on every cycle:
- the empty flag is set by reset and by each handover, and cleared by a read;
- the output holds between strobes;
- the output is 1 while multiframing is off;
- hunt mode sends bit 4;
- non-Q positions are 0 in sync.

Only the bench scenarios can show the rules that depend on what happened earlier. These are the full mapping of the four pattern bits across many buffer values, and repetition across multiframes. They also include protection of the current multiframe against a late write, and the latch taken when sync returns.

// File: rtl/qsched_pkg.sv
package qsched_pkg;

    localparam int Q_CNT = 4;
    localparam int BUF_W = Q_CNT + 1;

    typedef enum logic [1:0] {
        QM_OFF  = 2'd0,
        QM_HUNT = 2'd1,
        QM_LOCK = 2'd2
    } qmode_e;

    typedef struct packed {
        logic             fallback;
        logic [Q_CNT-1:0] pat;
    } qbuf_t;

    function automatic qmode_e mode_of(input logic en, input logic sync);
        if (!en)
            return QM_OFF;
        else if (!sync)
            return QM_HUNT;
        else
            return QM_LOCK;
    endfunction

endpackage

// File: rtl/qsched_hostbuf.sv
module qsched_hostbuf
    import qsched_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  qbuf_t wr_data,
    input  logic  stat_rd,
    input  logic  handover,
    output qbuf_t buf_q,
    output logic  empty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            empty <= 1'b1;
        end else begin
            if (wr_en)
                buf_q <= wr_data;
            if (handover)
                empty <= 1'b1;
            else if (stat_rd)
                empty <= 1'b0;
        end
    end

    p_set_on_handover_r1: assert property (@(posedge clk) disable iff (rst)
        handover |=> empty);

    p_read_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !handover) |=> !empty);

    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> empty);

endmodule

// File: rtl/qsched_slotter.sv
module qsched_slotter
    import qsched_pkg::*;
#(
    parameter int MF_LEN    = 20,
    parameter int Q_SPACING = 5,
    parameter int IDX_W     = $clog2(MF_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_stb,
    input  logic [IDX_W-1:0] frame_idx,
    input  qmode_e           mode,
    input  qbuf_t            buf_q,
    output logic             handover,
    output logic             q_bit
);

    logic [Q_CNT-1:0] hit;
    logic [Q_CNT-1:0] shadow;
    logic [Q_CNT-1:0] pat_now;
    logic             lock_bit;
    logic             q_next;

    for (genvar k = 0; k < Q_CNT; k++) begin : g_slot
        localparam int POS = 1 + k * Q_SPACING;
        assign hit[k] = (frame_idx == IDX_W'(POS));
    end

    assign handover = frame_stb && (mode == QM_LOCK) && hit[0];
    assign pat_now  = handover ? buf_q.pat : shadow;

    always_comb begin
        lock_bit = 1'b0;
        for (int k = 0; k < Q_CNT; k++)
            if (hit[k])
                lock_bit = pat_now[Q_CNT-1-k];
    end

    always_comb begin
        unique case (mode)
            QM_OFF:  q_next = 1'b1;
            QM_HUNT: q_next = buf_q.fallback;
            QM_LOCK: q_next = lock_bit;
            default: q_next = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            q_bit  <= 1'b1;
        end else begin
            if (handover)
                shadow <= buf_q.pat;
            if (frame_stb)
                q_bit <= q_next;
        end
    end

    p_hold_between_r11: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(q_bit));

    p_nonq_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && mode == QM_LOCK && hit == '0) |=> !q_bit);

    p_hit_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

endmodule

// File: rtl/qsched_tx.sv
module qsched_tx
    import qsched_pkg::*;
#(
    parameter int MF_LEN    = 20,
    parameter int Q_SPACING = 5,
    parameter int IDX_W     = $clog2(MF_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic [BUF_W-1:0] host_wdata,
    input  logic             stat_rd,
    input  logic             frame_stb,
    input  logic [IDX_W-1:0] frame_idx,
    input  logic             mf_en,
    input  logic             mf_sync,
    output logic             q_bit,
    output logic             buf_empty
);

    qbuf_t  wr_data;
    qbuf_t  buf_q;
    qmode_e mode;
    logic   handover;

    assign wr_data = qbuf_t'(host_wdata);
    assign mode    = mode_of(mf_en, mf_sync);

    qsched_hostbuf u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_wr),
        .wr_data  (wr_data),
        .stat_rd  (stat_rd),
        .handover (handover),
        .buf_q    (buf_q),
        .empty    (buf_empty)
    );

    qsched_slotter #(
        .MF_LEN    (MF_LEN),
        .Q_SPACING (Q_SPACING),
        .IDX_W     (IDX_W)
    ) u_slot (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .frame_idx (frame_idx),
        .mode      (mode),
        .buf_q     (buf_q),
        .handover  (handover),
        .q_bit     (q_bit)
    );

    p_off_ones_r10: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !mf_en) |=> q_bit);

    p_hunt_fallback_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && mf_en && !mf_sync) |=> (q_bit == $past(buf_q.fallback)));

    p_no_handover_unsynced_r9: assert property (@(posedge clk) disable iff (rst)
        (!mf_sync || !mf_en) |-> !handover);

endmodule

// File: tb/qsched_tx_tb.sv
module qsched_tx_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [4:0] host_wdata = '0;
    logic       stat_rd = 1'b0;
    logic       frame_stb = 1'b0;
    logic [4:0] frame_idx = 5'd1;
    logic       mf_en = 1'b0;
    logic       mf_sync = 1'b0;
    logic       q_bit;
    logic       buf_empty;

    int n_run = 0;
    int n_fail = 0;
    logic [4:0] m_buf = '0;
    logic [3:0] m_shadow = '0;

    always #2 clk = ~clk;

    qsched_tx u_dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .stat_rd(stat_rd), .frame_stb(frame_stb), .frame_idx(frame_idx),
        .mf_en(mf_en), .mf_sync(mf_sync), .q_bit(q_bit), .buf_empty(buf_empty)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic write_buf(input logic [4:0] v);
        host_wr = 1'b1; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
        m_buf = v;
    endtask

    task automatic read_stat();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    function automatic logic exp_q(input int idx);
        if (!mf_en) return 1'b1;
        if (!mf_sync) return m_buf[4];
        case (idx)
            1:  return m_shadow[3];
            6:  return m_shadow[2];
            11: return m_shadow[1];
            16: return m_shadow[0];
            default: return 1'b0;
        endcase
    endfunction

    task automatic frame(input int idx, input string req);
        logic e;
        frame_stb = 1'b1; frame_idx = 5'(idx);
        if (mf_en && mf_sync && idx == 1) m_shadow = m_buf[3:0];
        e = exp_q(idx);
        @(negedge clk);
        frame_stb = 1'b0;
        chk(req, q_bit, e);
        @(negedge clk);
        chk("R11", q_bit, e);
    endtask

    task automatic multiframe(input string req);
        for (int f = 1; f <= 20; f++) frame(f, req);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", buf_empty, 1'b1);
        chk("R11", q_bit, 1'b1);

        // R4: buffer bit 4 reset to 0, visible in hunt mode
        mf_en = 1'b1;
        frame(3, "R4");

        // R2: read clears the flag
        read_stat();
        chk("R2", buf_empty, 1'b0);

        // R3: hunt mode fallback sweep
        for (int v = 0; v < 32; v++) begin
            write_buf(5'(v));
            frame(1 + (v % 20), "R3");
        end
        chk("R9", buf_empty, 1'b0);

        // R10: multiframing disabled
        mf_en = 1'b0;
        write_buf(5'b0_0000);
        multiframe("R10");

        // R5/R6: sync sweep over every buffer value
        mf_en = 1'b1; mf_sync = 1'b1;
        for (int v = 0; v < 32; v++) begin
            write_buf(5'(v));
            read_stat();
            chk("R2", buf_empty, 1'b0);
            multiframe("R5");
            chk("R1", buf_empty, 1'b1);
        end

        // R7: repeat without reload
        multiframe("R7");
        multiframe("R7");

        // R8: late write does not affect the current multiframe
        write_buf(5'b0_1010);
        frame(1, "R8");
        write_buf(5'b0_0101);
        for (int f = 2; f <= 20; f++) frame(f, "R8");
        multiframe("R8");

        // R2: handover wins over a simultaneous read
        read_stat();
        stat_rd = 1'b1; frame_stb = 1'b1; frame_idx = 5'd1;
        m_shadow = m_buf[3:0];
        @(negedge clk);
        stat_rd = 1'b0; frame_stb = 1'b0;
        chk("R2", buf_empty, 1'b1);
        for (int f = 2; f <= 20; f++) frame(f, "R6");

        // R9: sync loss blocks handover, resync latches current buffer
        read_stat();
        mf_sync = 1'b0;
        write_buf(5'b1_1001);
        multiframe("R9");
        chk("R9", buf_empty, 1'b0);
        mf_sync = 1'b1;
        multiframe("R9");
        chk("R9", buf_empty, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule